// File: doc/BRIEF.md
# Transmit Frame Length Splitter

This block sits on a transmit byte stream, just ahead of the framer of an infrared physical layer. It cuts the stream into frames that are no longer than a programmed length. Each byte keeps its data. The block adds an end-of-frame marker on the last byte of each frame, so the framer knows where to close the current frame and open the next one. Flag insertion, CRC and line coding stay with the framer.

Software programs a 13-bit length through two byte-wide register halves. The length takes effect only while automatic packet mode is on. In that mode the block counts the bytes accepted in the current frame. When the count reaches the length, the block marks end-of-frame and starts counting again for the rest of the data. If the source ends its stream early, the frame closes on that byte instead. Reading the register halves returns the bytes still to be sent in the current frame, not the value that was written.

Top module: `tfs_splitter`

## Requirements
- R1: After reset the programmed length is zero, and both readback halves return 0x00.
- R2: A write with `reg_sel_i`=0 loads length bits 7:0 from `reg_wdata_i[7:0]`. A write with `reg_sel_i`=1 loads length bits 12:8 from `reg_wdata_i[4:0]`, and `reg_wdata_i[7:5]` is ignored. A read with `rd_sel_i`=1 returns the upper part in bits 4:0, and bits 7:5 always read as zero.
- R3: When no byte has been accepted in the current frame, the readback equals the programmed length.
- R4: The data path has no latency: `out_valid_o`=`in_valid_i`, `out_data_o`=`in_data_i` and `in_ready_o`=`out_ready_i`. A byte is accepted only in a cycle where `in_valid_i` and `out_ready_i` are both high.
- R5: With automatic packet mode on and a length N>0, `out_eof_o` is high together with the Nth accepted byte of every frame. After each accepted byte, the readback drops by one.
- R6: Once a byte carrying `out_eof_o` is accepted, the count starts again, and the readback returns N.
- R7: An accepted byte with `in_last_i` high carries `out_eof_o` and closes the frame early. The count then starts again.
- R8: If the length is zero, or automatic packet mode is off, `out_eof_o` follows `in_last_i` only. With the mode off, the readback equals the programmed length.
- R9: A cycle in which `in_valid_i` is high but `out_ready_i` is low does not change the count.
- R10: The count runs across the full 13-bit range. For example, with length 0x1003, after three accepted bytes the readback is 0x1000 (low half 0x00, high half 0x10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| apm_en_i | input | 1 | Automatic packet mode enable |
| reg_wr_i | input | 1 | Length register write strobe |
| reg_sel_i | input | 1 | Write half: 0 selects the low byte, 1 selects the high byte |
| reg_wdata_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read half: 0 selects the low byte, 1 selects the high byte |
| rd_data_o | output | 8 | Remaining-bytes readback |
| in_valid_i | input | 1 | Source byte valid |
| in_data_i | input | 8 | Source byte |
| in_last_i | input | 1 | Last byte of the source stream |
| in_ready_o | output | 1 | Block ready for a source byte |
| out_valid_o | output | 1 | Byte valid to the framer |
| out_data_o | output | 8 | Byte to the framer |
| out_eof_o | output | 1 | End of frame, given with the last byte of a frame |
| out_ready_i | input | 1 | Framer ready |

## Verification
The data path and `out_eof_o` are combinational in the same cycle. The bench therefore predicts the marker for each byte as soon as the byte is presented. It compares the marker one nanosecond after the falling edge, in the same cycle in which the byte is accepted at the next rising edge. The count and the readback change at the rising edge that accepts a byte. Readback checks are therefore made at the falling edge after that acceptance, and register writes are checked in the cycle after their write edge.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int unsigned LEN_W  = 13;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/tfs_len_regs.sv
module tfs_len_regs
  import tfs_pkg::*;
#(
  parameter int unsigned LW = LEN_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wr_sel_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          rd_sel_i,
  input  logic [LW-1:0] remain_i,
  output logic [BW-1:0] rdata_o,
  output logic [LW-1:0] len_o
);
  localparam int unsigned HW = LW - BW;

  logic [BW-1:0] lo_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_i) begin
      if (half_e'(wr_sel_i) == HALF_HI) hi_q <= wdata_i[HW-1:0];
      else                              lo_q <= wdata_i;
    end
  end

  assign len_o = {hi_q, lo_q};

  // high half zero-extended, unused upper bits read zero
  always_comb begin
    if (half_e'(rd_sel_i) == HALF_HI) rdata_o = BW'(remain_i[LW-1:BW]);
    else                              rdata_o = remain_i[BW-1:0];
  end
endmodule

// File: rtl/tfs_frame_ctr.sv
module tfs_frame_ctr
  import tfs_pkg::*;
#(
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          apm_i,
  input  logic [LW-1:0] len_i,
  input  logic          fire_i,
  input  logic          last_i,
  output logic          split_o,
  output logic          eof_o,
  output logic [LW-1:0] cnt_o,
  output logic [LW-1:0] remain_o
);
  logic [LW-1:0] cnt_q;
  logic [LW:0]   cnt_inc;
  logic          hit;

  assign split_o = apm_i && (len_i != '0);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // >= so a length shrunk below the count still closes the frame
  assign hit     = split_o && (cnt_inc >= {1'b0, len_i});
  assign eof_o   = last_i || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!split_o) cnt_q <= '0;
    else if (fire_i)  cnt_q <= eof_o ? '0 : cnt_inc[LW-1:0];
  end

  always_comb begin
    if (!split_o)          remain_o = len_i;
    else if (len_i > cnt_q) remain_o = len_i - cnt_q;
    else                   remain_o = '0;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tfs_stream_path.sv
module tfs_stream_path
  import tfs_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic          in_valid_i,
  input  logic [BW-1:0] in_data_i,
  output logic          in_ready_o,
  input  logic          eof_i,
  output logic          out_valid_o,
  output logic [BW-1:0] out_data_o,
  output logic          out_eof_o,
  input  logic          out_ready_i,
  output logic          fire_o
);
  assign out_valid_o = in_valid_i;
  assign out_data_o  = in_data_i;
  assign in_ready_o  = out_ready_i;
  assign out_eof_o   = in_valid_i && eof_i;
  assign fire_o      = in_valid_i && out_ready_i;
endmodule

// File: rtl/tfs_splitter.sv
module tfs_splitter
  import tfs_pkg::*;
#(
  parameter int unsigned LW = LEN_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          apm_en_i,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [BW-1:0] reg_wdata_i,
  input  logic          rd_sel_i,
  output logic [BW-1:0] rd_data_o,
  input  logic          in_valid_i,
  input  logic [BW-1:0] in_data_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [BW-1:0] out_data_o,
  output logic          out_eof_o,
  input  logic          out_ready_i
);
  logic [LW-1:0] len;
  logic [LW-1:0] remain;
  logic [LW-1:0] frame_cnt;
  logic          split_on;
  logic          eof_raw;
  logic          fire;

  tfs_len_regs #(.LW(LW), .BW(BW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wr_sel_i(reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rd_sel_i(rd_sel_i),
    .remain_i(remain),
    .rdata_o (rd_data_o),
    .len_o   (len)
  );

  tfs_frame_ctr #(.LW(LW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .apm_i   (apm_en_i),
    .len_i   (len),
    .fire_i  (fire),
    .last_i  (in_last_i),
    .split_o (split_on),
    .eof_o   (eof_raw),
    .cnt_o   (frame_cnt),
    .remain_o(remain)
  );

  tfs_stream_path #(.BW(BW)) u_path (
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .eof_i      (eof_raw),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_eof_o  (out_eof_o),
    .out_ready_i(out_ready_i),
    .fire_o     (fire)
  );
endmodule

// File: rtl/tfs_splitter_chk.sv
module tfs_splitter_chk #(
  parameter int unsigned LW = 13,
  parameter int unsigned BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_last_i,
  input logic          out_ready_i,
  input logic          out_eof_o,
  input logic          rd_sel_i,
  input logic [BW-1:0] rd_data_o,
  input logic          split_on,
  input logic [LW-1:0] frame_cnt,
  input logic [LW-1:0] len
);
  logic acc;
  assign acc = in_valid_i && out_ready_i;

  a_r2_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> rd_data_o[BW-1:LW-BW] == '0);

  a_r5_eof_at_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && split_on && ({1'b0, frame_cnt} + 1'b1 == {1'b0, len})) |-> out_eof_o);

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && split_on && !out_eof_o && $stable(len)) |=>
      (!split_on || frame_cnt == $past(frame_cnt) + 1'b1));

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && out_eof_o) |=> frame_cnt == '0);

  a_r7_last_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i) |-> out_eof_o);

  a_r8_no_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !split_on && !in_last_i) |-> !out_eof_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> frame_cnt <= $past(frame_cnt));
endmodule

bind tfs_splitter tfs_splitter_chk #(.LW(LW), .BW(BW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_last_i  (in_last_i),
  .out_ready_i(out_ready_i),
  .out_eof_o  (out_eof_o),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .split_on   (split_on),
  .frame_cnt  (frame_cnt),
  .len        (len)
);

// File: tb/tfs_splitter_tb_top.sv
`timescale 1ns/1ps
module tfs_splitter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       apm_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_eof;
  logic       out_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];

  // bench model
  int  m_len = 0;
  int  m_cnt = 0;
  bit  m_apm = 0;
  bit  stall = 0;
  bit  rdy_mode = 0;
  int  cyc = 0;

  always #2.5 clk = ~clk;

  tfs_splitter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .apm_en_i(apm_en),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_eof_o(out_eof), .out_ready_i(out_ready)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_split();
    return m_apm && (m_len != 0);
  endfunction

  function automatic int m_remain();
    if (!m_split()) return m_len;
    return (m_len > m_cnt) ? m_len - m_cnt : 0;
  endfunction

  always @(negedge clk) begin
    out_ready <= stall ? 1'b0 : (rdy_mode ? (cyc % 3 != 1) : 1'b1);
    cyc++;
  end

  // monitor: acceptance due at the next rising edge
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && in_valid && out_ready) begin
      chk("R4 valid", out_valid, 1);
      chk("R4 ready", in_ready, 1);
      if (exp_q.size() == 0) chk("R4 unexpected byte", 1, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R4 data", out_data, e[7:0]);
        chk("R5 R7 R8 eof", out_eof, e[8]);
      end
    end
  end

  task automatic wr_reg(bit sel, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel) m_len = (m_len & 'hff) | ((d & 'h1f) << 8);
    else     m_len = (m_len & 'h1f00) | d;
    m_cnt = 0;
  endtask

  task automatic set_len(int n);
    wr_reg(1'b0, n[7:0]);
    wr_reg(1'b1, n[15:8]);
  endtask

  task automatic rd_chk(string req);
    int r;
    r = m_remain();
    @(negedge clk);
    rd_sel = 1'b0; #1;
    chk(req, rd_data, r & 'hff);
    @(negedge clk);
    rd_sel = 1'b1; #1;
    chk(req, rd_data, (r >> 8) & 'h1f);
  endtask

  task automatic send(logic [7:0] d, bit last);
    bit e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    e = last || (m_split() && (m_cnt + 1 >= m_len));
    exp_q.push_back({e, d});
    do @(posedge clk); while (!out_ready);
    if (!m_split() || e) m_cnt = 0;
    else m_cnt++;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic burst(int n, int base);
    for (int i = 0; i < n; i++) send(8'(base + i), i == n - 1);
  endtask

  task automatic run_test();
    repeat (3) @(negedge clk);
    // R1: reset state
    rd_sel = 1'b0; #1; chk("R1 lo", rd_data, 0);
    rd_sel = 1'b1; #1; chk("R1 hi", rd_data, 0);
    chk("R1 R4 ready follows", in_ready, out_ready);
    rst_n = 1'b1;
    // R2: split writes, upper bits of high half ignored
    wr_reg(1'b0, 8'h05);
    wr_reg(1'b1, 8'hE1);
    rd_chk("R2 R8 len readback");
    @(negedge clk); rd_sel = 1'b1; #1;
    chk("R2 hi upper zero", rd_data, 8'h01);
    // R3/R5/R6/R7
    apm_en = 1'b1; m_apm = 1;
    set_len(4);
    rd_chk("R3 full length");
    rdy_mode = 1;
    send(8'h10, 0); send(8'h11, 0);
    rd_chk("R5 remaining");
    for (int i = 2; i < 9; i++) send(8'(8'h10 + i), 0);
    send(8'h19, 1);   // eofs on bytes 4, 8 and last (R7)
    rd_chk("R6 reload");
    // R9: stall
    send(8'h20, 0);
    stall = 1;
    @(negedge clk); in_valid = 1'b1; in_data = 8'h21;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    rd_chk("R9 stall holds");
    stall = 0;
    send(8'h22, 1);
    rd_chk("R7 early close");
    // R8: zero length, mode off
    set_len(0);
    burst(6, 'h30);
    set_len(3);
    apm_en = 1'b0; m_apm = 0;
    burst(5, 'h40);
    rd_chk("R8 mode off readback");
    // R10: full-width count
    apm_en = 1'b1; m_apm = 1;
    set_len('h1003);
    send(8'h50, 0); send(8'h51, 0); send(8'h52, 0);
    rd_chk("R10 wide count");
    send(8'h53, 1);
    repeat (3) @(negedge clk);
    chk("R4 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule